// File: doc/BRIEF.md
# I2C Bus Line Recovery Sequencer

A slave that is reset or interrupted in the middle of a read can keep SDA low indefinitely, and that blocks every later transfer on the bus. This block clears that condition before protocol traffic resumes. On a start request it reads the synchronized SCL and SDA levels. If both lines are already high it finishes at once without touching the bus. If either line is low, it takes SCL over and holds it low for a settle interval. It then clocks SCL: each pulse releases the line for one half period and pulls it low for another. Before each pulse it tests SDA and stops as soon as SDA reads high. It never issues more than a set number of pulses. When it gives SCL back, it waits one more settle interval and then reports the outcome.

The outputs are open-drain enables: a 1 pulls the line low. SDA is only watched and is never driven, so the slave is free to release it between clocks. All intervals are counted in system clocks. The count is the number of microseconds times a clocks-per-microsecond parameter. At the default values this gives 500 µs settle intervals, 1 ms half periods and a budget of ten pulses.

Top module: `i2c_bus_recover`

## Requirements
- R1: During and straight after reset, scl_oe_o, done_o and fail_o are all 0.
- R2: If SCL and SDA both read high when the start is taken, SCL is never driven and done_o rises on the first clock edge after the edge that captured start_i.
- R3: The line levels pass through a two-flop synchronizer, so the levels used are those captured two edges before the decision edge; a change made in the same cycle as the start request does not affect whether recovery begins.
- R4: When recovery is needed, SCL is driven low for SETTLE_US·CLK_PER_US cycles, then for one test cycle, before the first pulse.
- R5: Each pulse releases SCL for exactly HALF_US·CLK_PER_US cycles, then drives it low for the same count, followed by one test cycle.
- R6: Pulsing stops at the first test cycle that sees SDA high. With p pulses issued, done_o rises 2+2·S+p·(1+2·H) edges after the edge that captured start_i, where S and H are the settle and half-period cycle counts.
- R7: No more than MAX_PULSES pulses are issued. If SDA is still low at the test after the last allowed pulse, fail_o is 1 when done_o rises.
- R8: After the loop, SCL is released for S cycles before done_o. fail_o changes only on the edge where done_o rises or where a start is taken. It holds its value until the next accepted start.
- R9: start_i is ignored while a sequence is in progress, and the timing of that sequence does not change.
- R10: done_o is high for exactly one cycle per sequence, and SCL is released while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a check and, if needed, a recovery |
| scl_i | input | 1 | Sampled SCL line level (asynchronous) |
| sda_i | input | 1 | Sampled SDA line level (asynchronous) |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| done_o | output | 1 | One-cycle end-of-sequence strobe |
| fail_o | output | 1 | SDA still stuck after the full pulse budget |

## Verification
Two events can fall in the same cycle. The slave can release SDA on the very pulse that uses up the budget, so the early-exit test and the budget-exhausted test are evaluated together. The bench provokes this by making the slave model let go of SDA on exactly the tenth SCL rise. It then checks that fail_o stays 0, that ten pulses were counted, and that the total cycle count matches. In the same run a second start request arrives while the sequence is busy, and the bench checks that the result and timing are unchanged. A second case changes a line level in the same cycle as the start request and checks that the synchronizer's older value decides.

// File: rtl/i2c_bus_recover_pkg.sv
package i2c_bus_recover_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_HOLD,
    ST_TEST,
    ST_HIGH,
    ST_LOW,
    ST_REL,
    ST_DONE
  } rcv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q;
    // idle bus level is high
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/i2c_rcv_timer.sv
module i2c_rcv_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_pulse_cnt.sv
module i2c_pulse_cnt #(
  parameter int MAX = 10,
  localparam int W  = $clog2(MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_max_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign at_max_o = (cnt_q == W'(MAX));
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
  import i2c_bus_recover_pkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int SETTLE_US  = 500,
  parameter int HALF_US    = 1000,
  parameter int MAX_PULSES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic done_o,
  output logic fail_o
);
  localparam int SETTLE_CYC = SETTLE_US * CLK_PER_US;
  localparam int HALF_CYC   = HALF_US * CLK_PER_US;
  localparam int LONGEST    = (SETTLE_CYC > HALF_CYC) ? SETTLE_CYC : HALF_CYC;
  localparam int TW         = $clog2(LONGEST + 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] HALF_LD   = TW'(HALF_CYC - 1);

  rcv_state_e   state_q, state_d;
  logic [1:0]   lines_s;
  logic         scl_s, sda_s;
  logic         tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic         cnt_clr, cnt_inc, at_max;
  logic         pend_q, pend_d;
  logic         fail_q, fail_d;
  logic         scl_oe_q;
  logic         take_start;

  i2c_line_sync #(.N(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_rcv_timer #(.W(TW)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .zero_o(tmr_zero)
  );

  i2c_pulse_cnt #(.MAX(MAX_PULSES)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .at_max_o(at_max)
  );

  assign take_start = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = SETTLE_LD;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    pend_d   = pend_q;
    fail_d   = fail_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SAMPLE;
          cnt_clr = 1'b1;
          pend_d  = 1'b0;
          fail_d  = 1'b0;
        end
      end
      ST_SAMPLE: begin
        if (scl_s && sda_s) begin
          state_d = ST_DONE;
        end else begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
        end
      end
      ST_HOLD: if (tmr_zero) state_d = ST_TEST;
      ST_TEST: begin
        if (sda_s) begin
          state_d  = ST_REL;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
        end else if (at_max) begin
          state_d  = ST_REL;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
          pend_d   = 1'b1;
        end else begin
          state_d  = ST_HIGH;
          tmr_load = 1'b1;
          tmr_val  = HALF_LD;
          cnt_inc  = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tmr_zero) begin
          state_d  = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = HALF_LD;
        end
      end
      ST_LOW: if (tmr_zero) state_d = ST_TEST;
      ST_REL: begin
        if (tmr_zero) begin
          state_d = ST_DONE;
          fail_d  = pend_q;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pend_q   <= 1'b0;
      fail_q   <= 1'b0;
      scl_oe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      pend_q   <= pend_d;
      fail_q   <= fail_d;
      scl_oe_q <= (state_d == ST_HOLD) || (state_d == ST_TEST) || (state_d == ST_LOW);
    end
  end

  assign scl_oe_o = scl_oe_q;
  assign done_o   = (state_q == ST_DONE);
  assign fail_o   = fail_q;

  logic unused_take;
  assign unused_take = take_start;
endmodule

// File: rtl/i2c_bus_recover_chk.sv
module i2c_bus_recover_chk #(
  parameter int MAX_PULSES = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_oe_o,
  input logic done_o,
  input logic fail_o
);
  logic        prev_oe_q;
  int unsigned rise_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_oe_q  <= 1'b0;
      rise_cnt_q <= 0;
    end else begin
      prev_oe_q <= scl_oe_o;
      if (done_o)                       rise_cnt_q <= 0;
      else if (scl_oe_o && !prev_oe_q)  rise_cnt_q <= rise_cnt_q + 1;
    end
  end

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_released_at_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !scl_oe_o);

  assert_fail_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> done_o);

  assert_pulse_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_cnt_q <= MAX_PULSES + 1);
endmodule

bind i2c_bus_recover i2c_bus_recover_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_oe_o(scl_oe_o),
  .done_o  (done_o),
  .fail_o  (fail_o)
);

// File: tb/tb_i2c_bus_recover.sv
module tb_i2c_bus_recover;
  localparam int CPU  = 2;
  localparam int SUS  = 3;
  localparam int HUS  = 2;
  localparam int MAXP = 10;
  localparam int S    = SUS * CPU;
  localparam int H    = HUS * CPU;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic scl_stuck = 1'b0, hold = 1'b0;
  logic scl_oe, done, fail;
  int   remaining = 0;
  wire  scl_line = ~scl_oe & ~scl_stuck;
  wire  sda_line = ~hold;

  i2c_bus_recover #(.CLK_PER_US(CPU), .SETTLE_US(SUS), .HALF_US(HUS), .MAX_PULSES(MAXP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .done_o(done), .fail_o(fail)
  );

  always #5 clk = ~clk;

  // slave model: lets go of SDA after a given number of SCL rises
  always @(posedge scl_line) begin
    if (remaining > 0) begin
      remaining = remaining - 1;
      if (remaining == 0) hold = 1'b0;
    end
  end

  typedef struct { int cyc; int rises; bit fl; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor
  bit active = 0, prev_oe = 0, prev_done = 0;
  int cyc = 0, rises = 0, rel_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(!done, "R10", "done width", int'(done), 0);
      if (!active && start) begin
        active = 1; cyc = 0; rises = 0; rel_len = 0;
      end else if (active) begin
        cyc++;
        if (scl_oe && !prev_oe) begin
          if (rises > 0) chk(rel_len == H, "R5", "released width", rel_len, H);
          rises++;
          rel_len = 0;
        end else if (!scl_oe && rises > 0) begin
          rel_len++;
        end
        if (done) begin
          if (q.size() == 0) begin
            chk(0, "R10", "unexpected done", 1, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(cyc == e.cyc, e.tag, "cycles to done", cyc, e.cyc);
            chk(rises == e.rises, e.tag, "scl drive count", rises, e.rises);
            chk(fail == e.fl, e.tag, "fail flag", int'(fail), int'(e.fl));
          end
          active = 0;
        end
      end else if (done) begin
        chk(0, "R2", "done while idle", 1, 0);
      end
    end
    prev_oe   = scl_oe;
    prev_done = done;
  end

  task automatic run(int k, bit stuck, bit late, bit mid, string tag);
    exp_t e;
    int p;
    bit manual;
    manual = stuck || (k > 0) || late;
    p = late ? 0 : ((k > MAXP) ? MAXP : k);
    e.cyc   = manual ? 3 + 2 * S + p * (1 + 2 * H) : 2;
    e.rises = manual ? 1 + p : 0;
    e.fl    = (k > MAXP);
    e.tag   = tag;
    @(negedge clk);
    if (late) begin
      hold = 1'b1; remaining = 0;
    end else begin
      scl_stuck = stuck; hold = (k > 0); remaining = k;
    end
    repeat (4) @(negedge clk);
    q.push_back(e);
    if (late) hold = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    scl_stuck = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!scl_oe, "R1", "scl_oe in reset", int'(scl_oe), 0);
    chk(!done,   "R1", "done in reset",   int'(done),   0);
    chk(!fail,   "R1", "fail in reset",   int'(fail),   0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !done && !fail, "R1", "outputs after reset", int'({scl_oe, done, fail}), 0);

    run(0, 0, 0, 0, "R2");
    run(3, 0, 0, 0, "R6");
    run(11, 0, 0, 0, "R7");
    repeat (5) @(negedge clk);
    chk(fail, "R8", "fail held after done", int'(fail), 1);
    hold = 1'b0; remaining = 0;
    repeat (3) @(negedge clk);
    run(10, 0, 0, 1, "R9");
    run(0, 1, 0, 0, "R4");
    run(0, 0, 1, 0, "R3");
    run(1, 0, 0, 0, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule